// File: doc/BRIEF.md
# Socket Transmit Pointer Manager

This block keeps the transmit pointer state for one socket of an Ethernet offload controller. The host works through a small register strobe interface. It writes a new transmit write pointer after placing packet bytes in the buffer, then issues a SEND command. The write pointer has two separate storage locations. Host writes go to a shadow copy. Host reads return the committed copy, and that copy only changes when a transmission completes. A driver therefore has to keep its own running write address while it copies packet fragments, and must not read the pointer back between fragments.

When a SEND command is accepted, the block gives the transmit engine a one-cycle start pulse together with the byte range to send. When the engine reports that it is done, the committed write pointer and the read pointer both move to the sent end address, and an interrupt flag is set. The free-space value is recomputed every cycle from the pointers. None of the interfaces here carry streamed data, so there is no valid/ready pair and no back-pressure. The start pulse is a single-cycle strobe that the engine has to capture, and `eng_done` is sampled once for each edge.

Top module: `sock_txptr`

## Requirements
- R1: After reset, the WPTR (address 0) and RPTR (address 1) registers read 0, FREE (address 2) reads the buffer size (16384), CMD (address 3), INTF (address 4) and STAT (address 5) read 0, and `irq` is low.
- R2: A host write to WPTR does not change what WPTR, RPTR or FREE read back until a SEND completes. Host writes to RPTR, FREE and STAT have no effect.
- R3: Writing 0x20 (SEND) to CMD while idle raises `eng_start` for exactly one cycle, in the cycle after the write. In that cycle `eng_lo` equals RPTR and `eng_hi` equals the last value written to WPTR.
- R4: CMD reads back the written value for one cycle after the write, then reads 0. This holds whether or not the command was acted on.
- R5: While a send is in flight, STAT bit 0 reads 1 and WPTR/RPTR keep their old values. FREE reads 16384 minus the in-flight byte count. When idle, FREE reads 16384.
- R6: `eng_done` during a send causes the following on the next edge: WPTR and RPTR both read the sent end address, STAT bit 0 clears, INTF bit 0 sets, and `irq` rises.
- R7: A SEND written while a send is in flight produces no `eng_start`, and the in-flight end address is unchanged.
- R8: `eng_done` while idle changes no pointer and sets no flag.
- R9: Writing 1 to INTF bit 0 clears it, and writing 0 leaves it set. If a completion happens in the same cycle as a clear, the set wins.
- R10: Pointers are 16 bits and wrap modulo 65536. The in-flight count is (end − RPTR) mod 65536. FREE saturates at 0 when that count exceeds 16384.
- R11: WPTR writes made during a send are held in the shadow register and are used by the next accepted SEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host register write strobe |
| hw_addr | input | 3 | Host write register address |
| hw_data | input | 16 | Host write data |
| hr_addr | input | 3 | Host read register address |
| hr_data | output | 16 | Host read data (combinational from state) |
| eng_start | output | 1 | One-cycle transmit start pulse |
| eng_lo | output | 16 | Start pointer of the range to send, valid with eng_start |
| eng_hi | output | 16 | End pointer of the range to send, valid with eng_start |
| eng_done | input | 1 | Transmit engine completion strobe |
| irq | output | 1 | Send-complete interrupt, mirrors INTF bit 0 |

## Verification
A corrupt shadow or committed pointer shows up on the same cycle as a wrong WPTR read, or as a wrong `eng_hi` on the start pulse. A stale in-flight end address shows up only one completion later, as wrong WPTR and RPTR values after `eng_done`. A wrong busy state appears as a missing or extra `eng_start` in the cycle after a SEND write, or as a FREE value that does not return to the full size once the send is done. The bench sweeps send lengths and start pointers around the 16-bit wrap and the saturation point, so a wrong modular difference is seen on the first affected send.

// File: rtl/sock_txptr_pkg.sv
package sock_txptr_pkg;
  typedef enum logic [2:0] {
    A_WPTR = 3'd0,
    A_RPTR = 3'd1,
    A_FREE = 3'd2,
    A_CMD  = 3'd3,
    A_INTF = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;

  localparam logic [7:0] CMD_SEND = 8'h20;
endpackage

// File: rtl/sock_txptr_free.sv
module sock_txptr_free #(
  parameter int PTR_W     = 16,
  parameter int BUF_BYTES = 16384
) (
  input  logic [PTR_W-1:0] end_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] free
);
  localparam logic [PTR_W-1:0] BUF_V = PTR_W'(BUF_BYTES);

  logic [PTR_W-1:0] used;

  // Modular distance; wraps naturally at 2^PTR_W.
  always_comb begin
    used = end_ptr - rd_ptr;
    free = (used > BUF_V) ? '0 : (BUF_V - used);
  end
endmodule

// File: rtl/sock_txptr_seq.sv
module sock_txptr_seq
  import sock_txptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_val,
  input  logic [PTR_W-1:0] shadow,
  input  logic             eng_done,
  output logic [7:0]       cmd_q,
  output logic             busy,
  output logic             accept,
  output logic             commit,
  output logic [PTR_W-1:0] end_ptr,
  output logic [PTR_W-1:0] wr_vis,
  output logic [PTR_W-1:0] rd_ptr
);
  assign accept = (cmd_q == CMD_SEND) && !busy;
  assign commit = busy && eng_done;

  // Command register: holds a written value for one cycle, then self-clears.
  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_val;
    else             cmd_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      end_ptr <= '0;
      wr_vis  <= '0;
      rd_ptr  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      end_ptr <= shadow;
    end else if (commit) begin
      busy    <= 1'b0;
      wr_vis  <= end_ptr;
      rd_ptr  <= end_ptr;
    end
  end

  p_cmd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != 8'h00) && !cmd_wr |=> (cmd_q == 8'h00));

  p_vis_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(wr_vis) && $stable(rd_ptr)));

  p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !commit |=> $stable(end_ptr));

  p_commit_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (wr_vis == rd_ptr));
endmodule

// File: rtl/sock_txptr_host.sv
module sock_txptr_host
  import sock_txptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [2:0]       hw_addr,
  input  logic [PTR_W-1:0] hw_data,
  input  logic [2:0]       hr_addr,
  input  logic [PTR_W-1:0] wr_vis,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W-1:0] free,
  input  logic [7:0]       cmd_q,
  input  logic             busy,
  input  logic             commit,
  output logic [PTR_W-1:0] shadow,
  output logic             cmd_wr,
  output logic [7:0]       cmd_val,
  output logic             irq,
  output logic [PTR_W-1:0] hr_data
);
  logic send_ok;

  assign cmd_wr  = hw_en && (hw_addr == A_CMD);
  assign cmd_val = hw_data[7:0];
  assign irq     = send_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                              shadow <= '0;
    else if (hw_en && (hw_addr == A_WPTR))   shadow <= hw_data;
  end

  // Completion set has priority over a write-1 clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                                          send_ok <= 1'b0;
    else if (commit)                                     send_ok <= 1'b1;
    else if (hw_en && (hw_addr == A_INTF) && hw_data[0]) send_ok <= 1'b0;
  end

  always_comb begin
    case (hr_addr)
      A_WPTR:  hr_data = wr_vis;
      A_RPTR:  hr_data = rd_ptr;
      A_FREE:  hr_data = free;
      A_CMD:   hr_data = PTR_W'(cmd_q);
      A_INTF:  hr_data = PTR_W'(send_ok);
      A_STAT:  hr_data = PTR_W'(busy);
      default: hr_data = '0;
    endcase
  end

  p_flag_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);

  p_flag_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(hw_en && (hw_addr == A_INTF) && hw_data[0]) |=> irq);
endmodule

// File: rtl/sock_txptr.sv
module sock_txptr #(
  parameter int PTR_W     = 16,
  parameter int BUF_BYTES = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [2:0]       hw_addr,
  input  logic [PTR_W-1:0] hw_data,
  input  logic [2:0]       hr_addr,
  output logic [PTR_W-1:0] hr_data,
  output logic             eng_start,
  output logic [PTR_W-1:0] eng_lo,
  output logic [PTR_W-1:0] eng_hi,
  input  logic             eng_done,
  output logic             irq
);
  localparam logic [PTR_W-1:0] BUF_V = PTR_W'(BUF_BYTES);

  logic [PTR_W-1:0] shadow, end_ptr, wr_vis, rd_ptr, free;
  logic [7:0]       cmd_q, cmd_val;
  logic             cmd_wr, busy, accept, commit;

  sock_txptr_host #(.PTR_W(PTR_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_addr(hr_addr),
    .wr_vis(wr_vis), .rd_ptr(rd_ptr), .free(free),
    .cmd_q(cmd_q), .busy(busy), .commit(commit),
    .shadow(shadow), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .irq(irq), .hr_data(hr_data)
  );

  sock_txptr_seq #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_val(cmd_val), .shadow(shadow),
    .eng_done(eng_done),
    .cmd_q(cmd_q), .busy(busy), .accept(accept), .commit(commit),
    .end_ptr(end_ptr), .wr_vis(wr_vis), .rd_ptr(rd_ptr)
  );

  sock_txptr_free #(.PTR_W(PTR_W), .BUF_BYTES(BUF_BYTES)) u_free (
    .end_ptr(end_ptr), .rd_ptr(rd_ptr), .free(free)
  );

  assign eng_start = accept;
  assign eng_lo    = rd_ptr;
  assign eng_hi    = shadow;

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_idle_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (free == BUF_V));

  p_free_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free <= BUF_V);
endmodule

// File: tb/test_sock_txptr.sv
module test_sock_txptr;
  localparam int BUF = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_en = 1'b0;
  logic [2:0]  hw_addr = '0;
  logic [15:0] hw_data = '0;
  logic [2:0]  hr_addr = '0;
  logic [15:0] hr_data;
  logic        eng_start;
  logic [15:0] eng_lo, eng_hi;
  logic        eng_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  sock_txptr i_sock_txptr (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr),
    .hw_data(hw_data), .hr_addr(hr_addr), .hr_data(hr_data),
    .eng_start(eng_start), .eng_lo(eng_lo), .eng_hi(eng_hi),
    .eng_done(eng_done), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_reg(input logic [2:0] a);
    hr_addr = a;
    return hr_data;
  endfunction

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    hr_addr = a;
    #1;
    v = hr_data;
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_free(input logic [15:0] e, input logic [15:0] r);
    logic [15:0] u;
    u = e - r;
    return (u > 16'(BUF)) ? 16'd0 : 16'(BUF) - u;
  endfunction

  logic [15:0] v;
  logic [15:0] model_ptr;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd0, v); check("R1 wptr", v, 0);
    peek(3'd1, v); check("R1 rptr", v, 0);
    peek(3'd2, v); check("R1 free", v, BUF);
    peek(3'd3, v); check("R1 cmd", v, 0);
    peek(3'd4, v); check("R1 intf", v, 0);
    peek(3'd5, v); check("R1 stat", v, 0);
    check("R1 irq", irq, 0);

    // R2 read-only registers ignore writes
    wr(3'd1, 16'h1234); wr(3'd2, 16'h0007); wr(3'd5, 16'h0001);
    peek(3'd1, v); check("R2 rptr ro", v, 0);
    peek(3'd2, v); check("R2 free ro", v, BUF);
    peek(3'd5, v); check("R2 stat ro", v, 0);

    // R8 done while idle
    pulse_done();
    peek(3'd0, v); check("R8 wptr", v, 0);
    peek(3'd4, v); check("R8 intf", v, 0);

    // R4 unknown command clears without effect
    wr(3'd3, 16'h0055);
    check("R4 no start", eng_start, 0);
    peek(3'd3, v); check("R4 cmd held", v, 16'h0055);
    @(negedge clk);
    peek(3'd3, v); check("R4 cmd cleared", v, 0);
    peek(3'd5, v); check("R4 stays idle", v, 0);

    // Sweep of send lengths and start pointers, including wrap and saturation
    model_ptr = 16'h0000;
    for (int k = 0; k < 24; k++) begin
      logic [15:0] len, nxt;
      case (k)
        0: len = 16'd0;
        1: len = 16'd1;
        2: len = 16'(BUF - 1);
        3: len = 16'(BUF);
        4: len = 16'(BUF + 1);
        5: len = 16'hFFFF;
        default: len = 16'((k * 4099 + 7) % 20000);
      endcase
      if (k == 6) begin
        // move close to the 16-bit wrap point
        nxt = 16'hFFF0;
        wr(3'd0, nxt); wr(3'd3, 16'h0020); @(negedge clk); pulse_done();
        wr(3'd4, 16'h0001);
        model_ptr = nxt;
      end
      nxt = model_ptr + len;
      wr(3'd0, nxt);
      peek(3'd0, v); check("R2 wptr hidden", v, model_ptr);
      peek(3'd2, v); check("R2 free unchanged", v, BUF);
      wr(3'd3, 16'h0020);
      check("R3 start", eng_start, 1);
      check("R3 lo", eng_lo, model_ptr);
      check("R3 hi", eng_hi, nxt);
      peek(3'd3, v); check("R4 cmd send held", v, 16'h0020);
      @(negedge clk);
      check("R3 single pulse", eng_start, 0);
      peek(3'd3, v); check("R4 cmd send cleared", v, 0);
      peek(3'd5, v); check("R5 busy", v, 1);
      peek(3'd0, v); check("R5 wptr old", v, model_ptr);
      peek(3'd2, v); check("R10 free in flight", v, exp_free(nxt, model_ptr));
      pulse_done();
      peek(3'd0, v); check("R6 wptr", v, nxt);
      peek(3'd1, v); check("R6 rptr", v, nxt);
      peek(3'd5, v); check("R6 idle", v, 0);
      peek(3'd2, v); check("R5 free idle", v, BUF);
      check("R6 irq", irq, 1);
      wr(3'd4, 16'h0000);
      check("R9 write0 keeps", irq, 1);
      wr(3'd4, 16'h0001);
      check("R9 write1 clears", irq, 0);
      model_ptr = nxt;
    end

    // R7 / R11: SEND while busy ignored, shadow kept for next send
    wr(3'd0, model_ptr + 16'd100);
    wr(3'd3, 16'h0020);
    check("R7 first start", eng_start, 1);
    @(negedge clk);
    wr(3'd0, model_ptr + 16'd300);
    wr(3'd3, 16'h0020);
    check("R7 no start busy", eng_start, 0);
    peek(3'd3, v); check("R7 cmd held", v, 16'h0020);
    @(negedge clk);
    check("R7 still no start", eng_start, 0);
    peek(3'd3, v); check("R7 cmd cleared", v, 0);
    peek(3'd2, v); check("R7 free first range", v, BUF - 100);
    // R9: completion and clear in same cycle, set wins
    eng_done = 1'b1; hw_en = 1'b1; hw_addr = 3'd4; hw_data = 16'h0001;
    @(negedge clk);
    eng_done = 1'b0; hw_en = 1'b0;
    check("R9 set wins", irq, 1);
    peek(3'd0, v); check("R7 commit first", v, model_ptr + 16'd100);
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0020);
    check("R11 start", eng_start, 1);
    check("R11 hi from shadow", eng_hi, model_ptr + 16'd300);
    @(negedge clk);
    pulse_done();
    peek(3'd1, v); check("R11 rptr", v, model_ptr + 16'd300);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule